// File: doc/BRIEF.md
# Period-Synchronous Moving Average Filter

This block averages an oversampled stream of signed current samples over one switching period. Samples arrive with a valid flag at the acquisition rate. The default is ten samples per period: one every 2.5 µs at a 40 kHz switching frequency. A delay line holds the most recent `WIN` samples. A running sum takes in each new sample and drops the sample that leaves the window. The result is a boxcar filter with transfer function (1/N)(1 − z^−N)/(1 − z^−1).

The mean is not streamed out. A sampling trigger from the control timing marks the control step, once per switching period (every 25 µs by default). On that trigger the block divides the current window sum by `WIN` and presents the result for one cycle. The value then stays on the output until the next trigger, so the controller sees exactly one fresh average per step. The division is a fixed reciprocal multiply that is exact for every reachable sum. The running sum carries log2(N) guard bits.

Top module: `mavg_period_top`

## Requirements
- R1: While reset is asserted, `avg_vld_o` is 0 and `avg_data_o` is 0.
- R2: After reset, no strobe appears until `WIN` samples have been accepted, even if `sync_i` pulses earlier.
- R3: When `sync_i` is high at a clock edge and at least `WIN` samples were accepted before that edge, `avg_vld_o` is high for exactly the following cycle. `avg_vld_o` is never high in a cycle not preceded by such a trigger.
- R4: The strobed value is floor((S + floor(WIN/2)) / WIN), so halves round toward plus infinity. S is the sum of the `WIN` most recent samples accepted before the trigger edge. A sample accepted at the trigger edge itself is not part of S.
- R5: A cycle with `smp_vld_i` low leaves the window and the running sum unchanged, whatever is on `smp_data_i`.
- R6: Between strobes, `avg_data_o` holds the last strobed value.
- R7: Full-scale windows do not overflow. `WIN` samples of the most positive code give that code, and `WIN` samples of the most negative code give that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_vld_i | input | 1 | Sample valid, one pulse per acquisition |
| smp_data_i | input | DATA_W | Signed two's-complement sample |
| sync_i | input | 1 | Sampling trigger, one pulse per control step |
| avg_vld_o | output | 1 | One-cycle strobe for a fresh period average |
| avg_data_o | output | DATA_W | Signed period average, held between strobes |

## Verification
The assertions take for granted that samples are two's-complement values within `DATA_W` bits. They also assume that `sync_i` and `smp_vld_i` are single-cycle flags sampled on the clock, with no particular spacing between them. The stimulus meets this by driving every input half a cycle before the edge. It mixes trigger positions: with a sample, on an idle cycle, before the window is full, and several periods apart. It also places garbage data on idle cycles, full-scale codes, and small sums that land on the rounding halfway points.

// File: rtl/mavg_pkg.sv
package mavg_pkg;

  localparam int unsigned MAVG_DATA_W = 16;
  localparam int unsigned MAVG_WIN    = 10;

  // Reciprocal ceil(2^shift / win), used for an exact floor division.
  function automatic longint unsigned mavg_recip(input int unsigned shift,
                                                 input int unsigned win);
    return ((64'd1 << shift) + longint'(win) - 64'd1) / longint'(win);
  endfunction

endpackage

// File: rtl/mavg_rst_sync.sv
module mavg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/mavg_tap_line.sv
module mavg_tap_line #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] oldest
);

  logic signed [DATA_W-1:0] tap_q [DEPTH];
  logic signed [DATA_W-1:0] tap_d [DEPTH];

  always_comb begin
    tap_d = tap_q;
    if (shift_en) begin
      tap_d[0] = din;
      for (int i = 1; i < DEPTH; i++) tap_d[i] = tap_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tap_q[i] <= '0;
    end else begin
      tap_q <= tap_d;
    end
  end

  // Sample that drops out of the window when the next one enters.
  assign oldest = tap_q[DEPTH-1];

endmodule

// File: rtl/mavg_accum.sv
module mavg_accum #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WIN    = 10,
  parameter int unsigned SUM_W  = DATA_W + $clog2(WIN),
  parameter int unsigned CNT_W  = $clog2(WIN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     add_en,
  input  logic signed [DATA_W-1:0] new_smp,
  input  logic signed [DATA_W-1:0] old_smp,
  output logic signed [SUM_W-1:0]  sum_q,
  output logic [CNT_W-1:0]         cnt_q,
  output logic                     full
);

  localparam int unsigned EXT_W = SUM_W - DATA_W;

  logic signed [SUM_W-1:0] new_ext, old_ext, sum_d;
  logic [CNT_W-1:0]        cnt_d;

  assign new_ext = {{EXT_W{new_smp[DATA_W-1]}}, new_smp};
  assign old_ext = {{EXT_W{old_smp[DATA_W-1]}}, old_smp};
  assign full    = (cnt_q == CNT_W'(WIN));

  // R5: sum and fill count move only on an accepted sample.
  always_comb begin
    sum_d = sum_q;
    cnt_d = cnt_q;
    if (add_en) begin
      sum_d = sum_q + new_ext - old_ext;
      if (!full) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else begin
      sum_q <= sum_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mavg_scale.sv
module mavg_scale
  import mavg_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WIN    = 10,
  parameter int unsigned SUM_W  = DATA_W + $clog2(WIN)
) (
  input  logic signed [SUM_W-1:0]  sum_i,
  output logic signed [DATA_W-1:0] avg_o
);

  // Bias the sum to a non-negative value, divide exactly, then remove the bias.
  localparam int unsigned LOG_W = $clog2(WIN);
  localparam int unsigned M_W   = SUM_W + 1;
  localparam int unsigned SHIFT = M_W + LOG_W;
  localparam int unsigned RCP_W = M_W + 2;
  localparam int unsigned PRD_W = M_W + RCP_W;

  localparam longint unsigned RCP_L  = mavg_recip(SHIFT, WIN);
  localparam longint unsigned BIAS_L = longint'(WIN) * (64'd1 << (DATA_W - 1))
                                       + longint'(WIN / 2);

  localparam logic [RCP_W-1:0] RCP  = RCP_W'(RCP_L);
  localparam logic [M_W-1:0]   BIAS = M_W'(BIAS_L);

  logic [M_W-1:0]    biased;
  logic [PRD_W-1:0]  prod;
  logic [DATA_W-1:0] quo;

  assign biased = {sum_i[SUM_W-1], sum_i} + BIAS;
  assign prod   = PRD_W'(biased) * PRD_W'(RCP);
  assign quo    = DATA_W'(prod >> SHIFT);

  // Quotient carries an offset of 2^(DATA_W-1): flipping the MSB removes it.
  assign avg_o  = {~quo[DATA_W-1], quo[DATA_W-2:0]};

endmodule

// File: rtl/mavg_period_top.sv
module mavg_period_top
  import mavg_pkg::*;
#(
  parameter int unsigned DATA_W = MAVG_DATA_W,
  parameter int unsigned WIN    = MAVG_WIN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_vld_i,
  input  logic signed [DATA_W-1:0] smp_data_i,
  input  logic                     sync_i,
  output logic                     avg_vld_o,
  output logic signed [DATA_W-1:0] avg_data_o
);

  localparam int unsigned SUM_W = DATA_W + $clog2(WIN);
  localparam int unsigned CNT_W = $clog2(WIN + 1);

  logic                     rst_sync_n;
  logic signed [DATA_W-1:0] oldest_smp;
  logic signed [SUM_W-1:0]  run_sum;
  logic [CNT_W-1:0]         fill_cnt;
  logic                     win_full;
  logic signed [DATA_W-1:0] scaled;
  logic                     out_en;
  logic                     vld_d;
  logic signed [DATA_W-1:0] avg_d;

  mavg_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  mavg_tap_line #(.DATA_W(DATA_W), .DEPTH(WIN)) u_taps (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (smp_vld_i),
    .din      (smp_data_i),
    .oldest   (oldest_smp)
  );

  mavg_accum #(.DATA_W(DATA_W), .WIN(WIN), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .add_en  (smp_vld_i),
    .new_smp (smp_data_i),
    .old_smp (oldest_smp),
    .sum_q   (run_sum),
    .cnt_q   (fill_cnt),
    .full    (win_full)
  );

  mavg_scale #(.DATA_W(DATA_W), .WIN(WIN), .SUM_W(SUM_W)) u_scale (
    .sum_i (run_sum),
    .avg_o (scaled)
  );

  // R2/R3: release on the trigger only once the window holds WIN samples.
  assign out_en = sync_i & win_full;

  // R6: the output register loads only on a release.
  always_comb begin
    vld_d = out_en;
    avg_d = out_en ? scaled : avg_data_o;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      avg_vld_o  <= 1'b0;
      avg_data_o <= '0;
    end else begin
      avg_vld_o  <= vld_d;
      avg_data_o <= avg_d;
    end
  end

endmodule

// File: rtl/mavg_period_chk.sv
module mavg_period_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WIN    = 10,
  parameter int unsigned SUM_W  = DATA_W + $clog2(WIN),
  parameter int unsigned CNT_W  = $clog2(WIN + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smp_vld_i,
  input logic                     sync_i,
  input logic                     win_full,
  input logic [CNT_W-1:0]         fill_cnt,
  input logic signed [SUM_W-1:0]  run_sum,
  input logic                     avg_vld_o,
  input logic signed [DATA_W-1:0] avg_data_o
);

  localparam longint SUM_HI = longint'(WIN) * ((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam longint SUM_LO = -(longint'(WIN) * (64'sd1 <<< (DATA_W - 1)));

  // R2
  no_early_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_full |=> !avg_vld_o);

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(WIN));

  // R3
  strobe_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && win_full) |=> avg_vld_o);

  // R3
  strobe_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avg_vld_o |-> $past(sync_i));

  // R5
  idle_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i |=> $stable(run_sum));

  // R6
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_vld_o |-> $stable(avg_data_o));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (longint'(run_sum) <= SUM_HI) && (longint'(run_sum) >= SUM_LO));

endmodule

bind mavg_period_top mavg_period_chk #(.DATA_W(DATA_W), .WIN(WIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .smp_vld_i  (smp_vld_i),
  .sync_i     (sync_i),
  .win_full   (win_full),
  .fill_cnt   (fill_cnt),
  .run_sum    (run_sum),
  .avg_vld_o  (avg_vld_o),
  .avg_data_o (avg_data_o)
);

// File: tb/mavg_period_top_test.sv
`timescale 1ns/1ps
module mavg_period_top_test;

  localparam int DW  = 16;
  localparam int WIN = 10;

  logic                 clk;
  logic                 rst_n;
  logic                 smp_vld;
  logic signed [DW-1:0] smp_data;
  logic                 sync;
  logic                 avg_vld;
  logic signed [DW-1:0] avg_data;

  mavg_period_top #(.DATA_W(DW), .WIN(WIN)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld_i  (smp_vld),
    .smp_data_i (smp_data),
    .sync_i     (sync),
    .avg_vld_o  (avg_vld),
    .avg_data_o (avg_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  bit    chk_on = 0;
  string cur_req = "R4";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: queue of accepted samples.
  int    win_q[$];
  bit    exp_vld  = 0;
  int    exp_data = 0;
  string vld_tag  = "R2";

  function automatic int floor_avg(input int s);
    int n, q;
    n = s + WIN / 2;
    q = n / WIN;
    if ((n % WIN != 0) && (n < 0)) q = q - 1;
    return q;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      win_q.delete();
      exp_vld  = 0;
      exp_data = 0;
      vld_tag  = "R2";
    end else begin
      vld_tag = (win_q.size() >= WIN) ? "R3" : "R2";
      exp_vld = sync && (win_q.size() >= WIN);
      if (exp_vld) begin
        int s;
        s = 0;
        foreach (win_q[i]) s += win_q[i];
        exp_data = floor_avg(s);
      end
      if (smp_vld) begin
        win_q.push_back(int'(smp_data));
        if (win_q.size() > WIN) void'(win_q.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      check(avg_vld == exp_vld, vld_tag, int'(avg_vld), int'(exp_vld));
      check(int'(avg_data) == exp_data, exp_vld ? cur_req : "R6",
            int'(avg_data), exp_data);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(input bit v, input int d, input bit s);
    @(negedge clk);
    smp_vld  = v;
    smp_data = DW'(d);
    sync     = s;
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic int next_rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr));
  endfunction

  // One window of WIN identical samples followed by a trigger on an idle cycle.
  task automatic flat_window(input int val);
    for (int i = 0; i < WIN; i++) drive(1, val, 0);
    drive(0, 0, 1);
    drive(0, 0, 0);
  endtask

  task automatic spike_window(input int val);
    for (int i = 0; i < WIN - 1; i++) drive(1, 0, 0);
    drive(1, val, 0);
    drive(0, 0, 1);
    drive(0, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    smp_vld = 1'b0;
    smp_data = '0;
    sync = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(avg_vld == 1'b0, "R1", int'(avg_vld), 0);
    check(avg_data == '0, "R1", int'(avg_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1;

    // R2: triggers before the window has filled must stay silent.
    for (int i = 0; i < WIN - 1; i++) drive(1, 3 * i - 7, 1);
    drive(1, 40, 1);        // sample at the edge is not counted yet
    drive(0, 0, 1);         // now full: strobe expected (R3)
    drive(0, 0, 0);

    // R4: periodic operation, trigger coincident with the first sample of a period.
    cur_req = "R4";
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < WIN; i++) drive(1, next_rnd(), i == 0);
    end
    drive(0, 0, 1);
    drive(0, 0, 0);

    // R4: rounding halfway points.
    spike_window(5);    // 1
    spike_window(-5);   // 0
    spike_window(-6);   // -1
    spike_window(15);   // 2
    spike_window(-15);  // -1
    spike_window(4);    // 0

    // R5: garbage on idle cycles must not enter the window.
    cur_req = "R5";
    for (int i = 0; i < WIN; i++) begin
      drive(1, 100, 0);
      drive(0, 16'h7ABC, 0);
      drive(0, -31000, 0);
    end
    drive(0, 12345, 1);
    drive(0, -1, 0);

    // R6: long stretch without triggers, output must hold.
    for (int i = 0; i < 25; i++) drive(1, next_rnd(), 0);

    // R7: full-scale extremes.
    cur_req = "R7";
    flat_window(32767);
    flat_window(-32768);
    flat_window(32767);

    // R3: back-to-back triggers each produce a strobe.
    cur_req = "R4";
    for (int i = 0; i < 2 * WIN; i++) drive(1, next_rnd(), (i % 3) == 0);
    drive(0, 0, 1);
    drive(0, 0, 1);
    drive(0, 0, 0);
    repeat (3) drive(0, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule